// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave on a four-wire synchronous serial link: serial clock, serial data in, serial data out and an active-low select. It runs in the system clock domain and oversamples the serial clock to find its edges. Every transfer starts with an 8-bit command byte. A register-access command either reads or writes one word of a 24-bit register bank that lives outside this block. Any other command byte is passed on as a one-cycle strobe.

A write command takes exactly three more bytes from the master and commits them as one word. A read command takes a snapshot of the addressed word into an output buffer and shifts it out while the master goes on sending bytes. Because of this, further commands, including a write or a second read, are decoded and executed while an earlier read is still on the data-out line. Reads are chained by placing the next read command in the third byte of the current readout.

The register bank is reached through a plain bus: a combinational read address with a read strobe and returned data, and a registered write pulse with address and data. The bank has a configuration word at address 0, offsets for the two channels at 1 and 3, and the two conversion results at 7 and 8. Only the configuration word has reserved bits.

Top module: `ser_reg_if`

## Requirements
- R1: After reset `sdo` is 0, and no write pulse and no command strobe is issued until the master clocks in a complete command.
- R2: With select low, `sdi` is sampled on each rising `sclk` edge and bytes arrive MSB first. In a command byte, bit 7 = 0 marks a register access, bit 6 = 1 selects write and 0 selects read, bits 5:1 carry the register address and bit 0 is ignored.
- R3: A write command is followed by exactly 24 data bits, MSB first. No write is issued before the 24th data rising edge. One clock after that edge, `wr_en` pulses for one cycle, carrying the latched address and all 24 bits together.
- R4: A write to address 0 keeps only bits 7:0 and forces bits 23:8 to zero. Writes to every other address keep all 24 bits.
- R5: On the 8th rising edge of a read command, `rd_en` pulses, the word on `rd_data` is snapshotted and `sdo` presents bit 23 at the next falling edge. Each later falling edge presents the next lower bit, 24 bits in all, and after that `sdo` returns to 0.
- R6: A readout already under way shifts out its snapshot unchanged, even if the same register is written while it is shifting.
- R7: Command bytes are decoded while a readout is in progress. A read command that completes on the 24th bit of a readout continues on the very next falling edge with the new word, with no gap. A write command sent during a readout is carried out.
- R8: A command byte with bit 7 = 1 produces a one-cycle `cmd_stb` pulse, one clock after its 8th rising edge, with the byte on `cmd_code`, and does not touch the register bank.
- R9: Raising `cs_n` abandons any partial command byte or partial write data without a write, ends any readout with `sdo` at 0, and masks `sclk` edges for as long as it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select for the serial link |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master |
| rd_en | output | 1 | Read strobe, same cycle as the snapshot |
| rd_addr | output | 5 | Register address for the read |
| rd_data | input | 24 | Word returned by the bank for `rd_addr` |
| wr_en | output | 1 | One-cycle write pulse |
| wr_addr | output | 5 | Register address for the write |
| wr_data | output | 24 | Write word with reserved bits cleared |
| cmd_stb | output | 1 | One-cycle strobe for a non-register command |
| cmd_code | output | 8 | The non-register command byte |

## Verification
A bit counter that loses step with the master misframes the next command byte. That shows up within one byte time, as a wrong word on `sdo`, a missing write, or a strobe where none was sent. A fault in the output buffer or its count shows on `sdo` at the first falling edge after the read command, or as a readout that ends too early or too late. A write latched with the wrong address or mask, or a snapshot that follows later writes, only appears when the word is read back. For that reason, every write scenario in the bench ends with a readback.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;

    localparam int SR_ADDR_W = 5;
    localparam int SR_DATA_W = 24;
    localparam int SR_CMD_W  = 8;

    typedef enum logic {
        PH_CMD   = 1'b0,
        PH_WDATA = 1'b1
    } ser_phase_e;

endpackage

// File: rtl/sclk_edge.sv
module sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic rise,
    output logic fall
);

    logic sclk_d, sclk_q;

    always_comb begin
        sclk_d = sclk;
        rise   = !cs_n &&  sclk && !sclk_q;
        fall   = !cs_n && !sclk &&  sclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_d;
    end

endmodule

// File: rtl/cmd_rx.sv
module cmd_rx
    import ser_reg_pkg::*;
#(
    parameter int ADDR_W   = SR_ADDR_W,
    parameter int DATA_W   = SR_DATA_W,
    parameter int CMD_W    = SR_CMD_W,
    parameter int CFG_ADDR = 0,
    parameter logic [DATA_W-1:0] CFG_WMASK = 24'h0000FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rise,
    input  logic              sdi,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cmd_stb,
    output logic [CMD_W-1:0]  cmd_code
);

    localparam int CNT_W     = $clog2(DATA_W);
    localparam int CMD_LAST  = CMD_W - 1;
    localparam int DATA_LAST = DATA_W - 1;

    typedef struct packed {
        ser_phase_e          phase;
        logic [CNT_W-1:0]    cnt;
        logic [CMD_W-2:0]    cmd_sh;
        logic [DATA_W-2:0]   data_sh;
        logic [ADDR_W-1:0]   waddr;
        logic                wen;
        logic [DATA_W-1:0]   wdata;
        logic                stb;
        logic [CMD_W-1:0]    code;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic [CMD_W-1:0]  byte_w;
    logic [DATA_W-1:0] word_w;
    logic [DATA_W-1:0] keep_mask;

    always_comb begin
        s_d       = s_q;
        s_d.wen   = 1'b0;
        s_d.stb   = 1'b0;
        rd_en     = 1'b0;
        byte_w    = {s_q.cmd_sh, sdi};
        word_w    = {s_q.data_sh, sdi};
        keep_mask = (s_q.waddr == ADDR_W'(CFG_ADDR)) ? CFG_WMASK : '1;
        if (cs_n) begin
            s_d.phase = PH_CMD;
            s_d.cnt   = '0;
        end else if (rise) begin
            if (s_q.phase == PH_CMD) begin
                s_d.cmd_sh = byte_w[CMD_W-2:0];
                if (s_q.cnt == CNT_W'(CMD_LAST)) begin
                    s_d.cnt = '0;
                    if (byte_w[CMD_W-1]) begin
                        s_d.stb  = 1'b1;
                        s_d.code = byte_w;
                    end else if (byte_w[CMD_W-2]) begin
                        s_d.phase = PH_WDATA;
                        s_d.waddr = byte_w[ADDR_W:1];
                    end else begin
                        rd_en = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else begin
                s_d.data_sh = word_w[DATA_W-2:0];
                if (s_q.cnt == CNT_W'(DATA_LAST)) begin
                    s_d.wen   = 1'b1;
                    s_d.wdata = word_w & keep_mask;
                    s_d.phase = PH_CMD;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_addr  = byte_w[ADDR_W:1];
    assign wr_en    = s_q.wen;
    assign wr_addr  = s_q.waddr;
    assign wr_data  = s_q.wdata;
    assign cmd_stb  = s_q.stb;
    assign cmd_code = s_q.code;

    // R3
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wen |=> !s_q.wen);

    // R9
    cs_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!s_q.wen && s_q.phase == PH_CMD && s_q.cnt == '0));

    // R8
    stb_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stb |=> !s_q.stb);

    // R2
    cmd_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_CMD) |-> (s_q.cnt < CNT_W'(CMD_W)));

endmodule

// File: rtl/rd_shifter.sv
module rd_shifter
    import ser_reg_pkg::*;
#(
    parameter int DATA_W = SR_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              fall,
    output logic              sdo
);

    localparam int LEFT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [LEFT_W-1:0] left;
        logic              out;
    } tx_state_t;

    tx_state_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (abort) begin
            t_d.left = '0;
            t_d.out  = 1'b0;
        end else if (load) begin
            t_d.sh   = load_data;
            t_d.left = LEFT_W'(DATA_W);
        end else if (fall) begin
            if (t_q.left != '0) begin
                t_d.out  = t_q.sh[DATA_W-1];
                t_d.sh   = t_q.sh << 1;
                t_d.left = t_q.left - 1'b1;
            end else begin
                t_d.out  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign sdo = t_q.out;

    // R5
    load_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !abort) |=> (t_q.left == LEFT_W'(DATA_W)));

    // R5
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !abort) |=> $stable(sdo));

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !load && !abort && t_q.left == '0) |=> !sdo);

    // R9
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!sdo && t_q.left == '0));

endmodule

// File: rtl/ser_reg_if.sv
module ser_reg_if
    import ser_reg_pkg::*;
#(
    parameter int ADDR_W   = SR_ADDR_W,
    parameter int DATA_W   = SR_DATA_W,
    parameter int CMD_W    = SR_CMD_W,
    parameter int CFG_ADDR = 0,
    parameter logic [DATA_W-1:0] CFG_WMASK = 24'h0000FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cmd_stb,
    output logic [CMD_W-1:0]  cmd_code
);

    logic rise, fall;

    sclk_edge edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .cs_n  (cs_n),
        .rise  (rise),
        .fall  (fall)
    );

    cmd_rx #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CMD_W     (CMD_W),
        .CFG_ADDR  (CFG_ADDR),
        .CFG_WMASK (CFG_WMASK)
    ) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rise     (rise),
        .sdi      (sdi),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmd_stb  (cmd_stb),
        .cmd_code (cmd_code)
    );

    rd_shifter #(
        .DATA_W (DATA_W)
    ) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (cs_n),
        .load      (rd_en),
        .load_data (rd_data),
        .fall      (fall),
        .sdo       (sdo)
    );

endmodule

// File: tb/ser_reg_if_tb.sv
`timescale 1ns/1ps
module ser_reg_if_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        rd_en;
    logic [4:0]  rd_addr;
    logic [23:0] rd_data;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [23:0] wr_data;
    logic        cmd_stb;
    logic [7:0]  cmd_code;

    int n_tests = 0;
    int n_fail  = 0;

    logic [23:0] bank [32];
    int          wr_cnt, stb_cnt;
    logic [4:0]  last_wa;
    logic [23:0] last_wd;
    logic [7:0]  last_code;

    always #4 clk = ~clk;

    ser_reg_if dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_stb(cmd_stb), .cmd_code(cmd_code)
    );

    assign rd_data = bank[rd_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) bank[i] <= 24'h3C5A00 + 24'(i) * 24'h010203;
            wr_cnt  <= 0;
            stb_cnt <= 0;
            last_wa <= '0;
            last_wd <= '0;
            last_code <= '0;
        end else begin
            if (wr_en) begin
                bank[wr_addr] <= wr_data;
                wr_cnt  <= wr_cnt + 1;
                last_wa <= wr_addr;
                last_wd <= wr_data;
            end
            if (cmd_stb) begin
                stb_cnt   <= stb_cnt + 1;
                last_code <= cmd_code;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            sdi = tx[i];
            repeat (4) @(negedge clk);
            rx[i] = sdo;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic send_read(input logic [4:0] a, input logic [7:0] f0, input logic [7:0] f1,
                             input logic [7:0] f2, output logic [23:0] w);
        logic [7:0] r;
        xfer({2'b00, a, 1'b0}, 8, r);
        xfer(f0, 8, r); w[23:16] = r;
        xfer(f1, 8, r); w[15:8]  = r;
        xfer(f2, 8, r); w[7:0]   = r;
    endtask

    task automatic send_write(input logic [4:0] a, input logic [23:0] w);
        logic [7:0] r;
        xfer({2'b01, a, 1'b0}, 8, r);
        xfer(w[23:16], 8, r);
        xfer(w[15:8], 8, r);
        xfer(w[7:0], 8, r);
    endtask

    task automatic t_reset();
        chk(sdo == 1'b0, "R1 sdo after reset", 32'(sdo), 0);
        chk(wr_cnt == 0 && stb_cnt == 0, "R1 no activity after reset", 32'(wr_cnt + stb_cnt), 0);
    endtask

    task automatic t_write_read();
        logic [7:0] r;
        logic [23:0] w;
        int base = wr_cnt;
        xfer(8'h42, 8, r);
        xfer(8'h12, 8, r);
        xfer(8'h34, 8, r);
        chk(wr_cnt == base, "R3 no commit before 24th bit", 32'(wr_cnt - base), 0);
        xfer(8'h56, 8, r);
        chk(wr_cnt == base + 1, "R3 single commit", 32'(wr_cnt - base), 1);
        chk(last_wa == 5'd1 && last_wd == 24'h123456, "R3 write addr/data",
            {3'b0, last_wa, last_wd}, {8'd1, 24'h123456});
        send_read(5'd1, 8'hA0, 8'hA0, 8'hA0, w);
        chk(w == 24'h123456, "R5 readback addr 1", 32'(w), 32'h123456);
        send_read(5'd3, 8'hA0, 8'hA0, 8'hA0, w);
        chk(w == 24'h3C5A00 + 24'h030609, "R2 read addr 3 initial", 32'(w), 32'h3C5A00 + 32'h030609);
        chk(sdo == 1'b0, "R5 sdo zero after 24 bits", 32'(sdo), 0);
    endtask

    task automatic t_reserved();
        logic [23:0] w;
        send_write(5'd0, 24'hFFFFFF);
        chk(last_wd == 24'h0000FF, "R4 config mask on bus", 32'(last_wd), 32'hFF);
        send_read(5'd0, 8'hA0, 8'hA0, 8'hA0, w);
        chk(w == 24'h0000FF, "R4 config readback", 32'(w), 32'hFF);
        send_write(5'd3, 24'hFEDCBA);
        send_read(5'd3, 8'hA0, 8'hA0, 8'hA0, w);
        chk(w == 24'hFEDCBA, "R4 full word at addr 3", 32'(w), 32'hFEDCBA);
    endtask

    task automatic t_strobe();
        logic [7:0] r;
        int sb = stb_cnt;
        int wb = wr_cnt;
        xfer(8'hE8, 8, r);
        chk(stb_cnt == sb + 1 && last_code == 8'hE8, "R8 strobe code",
            {16'(stb_cnt - sb), last_code}, {16'd1, 8'hE8});
        chk(wr_cnt == wb, "R8 strobe writes nothing", 32'(wr_cnt - wb), 0);
    endtask

    task automatic t_snapshot();
        logic [7:0] r;
        logic [23:0] w;
        send_write(5'd3, 24'h0F1E2D);
        send_read(5'd3, 8'h46, 8'h55, 8'h66, w);
        xfer(8'h77, 8, r);
        chk(w == 24'h0F1E2D, "R6 snapshot kept during write", 32'(w), 32'h0F1E2D);
        send_read(5'd3, 8'hA0, 8'hA0, 8'hA0, w);
        chk(w == 24'h556677, "R7 write during readout applied", 32'(w), 32'h556677);
    endtask

    task automatic t_chain();
        logic [7:0] r;
        logic [23:0] w1, w2;
        send_read(5'd7, 8'hA0, 8'hA0, 8'h10, w1);
        xfer(8'hA0, 8, r); w2[23:16] = r;
        xfer(8'hA0, 8, r); w2[15:8]  = r;
        xfer(8'hA0, 8, r); w2[7:0]   = r;
        chk(w1 == 24'h3C5A00 + 24'h070E15, "R7 chained first word", 32'(w1), 32'h3C5A00 + 32'h070E15);
        chk(w2 == 24'h3C5A00 + 24'h081018, "R7 chained second word", 32'(w2), 32'h3C5A00 + 32'h081018);
    endtask

    task automatic t_cs_abort();
        logic [7:0] r;
        logic [23:0] w;
        int wb;
        send_write(5'd1, 24'hABCDEF);
        wb = wr_cnt;
        xfer(8'h42, 8, r);
        xfer(8'h99, 8, r);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        sclk = 1'b1; repeat (4) @(negedge clk); sclk = 1'b0; repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        xfer(8'h42, 5, r);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(wr_cnt == wb, "R9 no write on abandon", 32'(wr_cnt - wb), 0);
        send_read(5'd1, 8'hA0, 8'hA0, 8'hA0, w);
        chk(w == 24'hABCDEF, "R9 register unchanged, framing restored", 32'(w), 32'hABCDEF);
        xfer(8'h0E, 8, r);
        xfer(8'hA0, 3, r);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sdo == 1'b0, "R9 readout ended by deselect", 32'(sdo), 0);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        t_write_read();
        t_reserved();
        t_strobe();
        t_snapshot();
        t_chain();
        t_cs_abort();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule